// File: doc/BRIEF.md
# Master clock source selector

This block picks the master clock that downstream audio logic runs on. There are two candidate sources: a PLL clock and a crystal-oscillator clock. The PLL path can first be halved. The block hands over between the sources without producing short pulses. It falls back to the oscillator by itself when the PLL reports loss of lock. When software asks for the oscillator while the amplifier is stopped, the block first starts the amplifier. It moves the output across only after a startup interval has elapsed. A second output carries the selected clock divided by 1, 2 or 4.

A rate monitor counts selected-clock edges over a window of reference-clock cycles and compares each count against the previous one. A switch onto a cold oscillator wipes the stored count, so the next window reports a single error pulse. That pulse does not appear when the amplifier is held running, or when error reporting is masked. Windows that overlap a handover are discarded.

Top module: `mclk_source_sel`

## Requirements
- R1: With the PLL locked and `cfg_src_osc` low, `mclk_out` follows the PLL-path clock.
- R2: When `pll_lock` falls, `amp_en` rises within a few `ref_clk` cycles and the output later moves to the oscillator, with no change to any control input.
- R3: After `amp_en` rises from a stopped amplifier, `mclk_out` does not take the oscillator clock until `OSC_STARTUP` oscillator cycles have been counted.
- R4: A request back to the PLL (`cfg_src_osc` low, PLL locked) moves `mclk_out` to the PLL path within 500 ns at the bench rates, with no startup wait.
- R5: The two source enables are never high together, and `mclk_out` never has a high or low phase shorter than half a period of the active source.
- R6: With `cfg_amp_always` high, `amp_en` is held high and a switch to the oscillator needs no startup wait.
- R7: A switch onto a stopped oscillator, with masking off, makes `rate_err` rise exactly once. The pulse lasts exactly one window of `cfg_win_len` reference cycles.
- R8: With `cfg_err_mask` high, `rate_err` never rises, including across a cold switch.
- R9: With `cfg_amp_always` high, switching between equal-rate sources leaves `rate_err` low.
- R10: `cfg_pll_div2` = 0 passes the PLL clock straight through; `cfg_pll_div2` = 1 halves it.
- R11: `cfg_aux_div` code 0 gives `aux_clk_out` at the `mclk_out` rate, code 1 gives half that rate, and codes 2 and 3 give a quarter of it.
- R12: While window counts stay within `RATE_TOL` of the previous window, `rate_err` stays low. A step larger than that raises `rate_err` for one window, after which it returns low once the rate is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Control and monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk | input | 1 | PLL output clock |
| pll_lock | input | 1 | PLL lock indication (asynchronous) |
| osc_clk | input | 1 | Crystal-oscillator clock |
| cfg_src_osc | input | 1 | 1 requests the oscillator, 0 requests the PLL |
| cfg_amp_always | input | 1 | 1 keeps the oscillator amplifier running |
| cfg_err_mask | input | 1 | 1 keeps rate changes off `rate_err` |
| cfg_pll_div2 | input | 1 | 1 halves the PLL clock before the selector |
| cfg_aux_div | input | 2 | Auxiliary divide code (0:/1, 1:/2, 2 or 3:/4) |
| cfg_win_len | input | WIN_W | Monitor window length in `ref_clk` cycles |
| mclk_out | output | 1 | Selected master clock |
| aux_clk_out | output | 1 | Divided auxiliary clock |
| amp_en | output | 1 | Oscillator amplifier enable |
| rate_err | output | 1 | Rate-change error flag |

## Verification
The bench goes after the handover corners: timing the output source against the startup count, the return to the PLL, and the fallback on loss of lock. A design that skips the startup wait would show oscillator edges too early. A design with a broken handshake would emit a runt pulse, and the bench's pulse-width tracker catches that. The bench counts error pulses across a cold switch, a masked cold switch, an always-running switch and a PLL rate step. A design that forgot to discard handover windows, or that cleared the stored count on the wrong kind of switch, would show extra or missing pulses. It also sweeps every auxiliary and PLL divide code and measures the resulting periods.

// File: rtl/mclk_sel_pkg.sv
`timescale 1ns/1ps
package mclk_sel_pkg;

  // number of binary divider stages selected by an auxiliary divide code
  function automatic logic [1:0] aux_tap(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // absolute difference of two window counts compared against a tolerance
  function automatic logic rate_deviates(input logic [15:0] a,
                                         input logic [15:0] b,
                                         input logic [7:0]  tol);
    logic [15:0] diff;
    diff = (a > b) ? (a - b) : (b - a);
    return diff > {8'd0, tol};
  endfunction

endpackage

// File: rtl/mclk_osc_startup.sv
`timescale 1ns/1ps
module mclk_osc_startup #(
  parameter int STARTUP = 1024
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic amp_en,
  output logic osc_run
);
  localparam int CW = $clog2(STARTUP + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP - 1);

  logic [1:0]    en_sync;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sync <= 2'b00;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      en_sync <= {en_sync[0], amp_en};
      if (!en_sync[1]) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (!run_q) begin
        if (cnt_q == LAST) run_q <= 1'b1;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign osc_run = run_q;
endmodule

// File: rtl/mclk_glitchfree_mux.sv
`timescale 1ns/1ps
module mclk_glitchfree_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic pick_b,
  input  logic b_ok,
  output logic clk_o,
  output logic a_on,
  output logic b_on
);
  logic [SYNC_STAGES-1:0] a_q;
  logic [SYNC_STAGES-1:0] b_q;
  logic a_want, b_want;

  assign a_want = ~pick_b & ~b_on;
  assign b_want = pick_b & b_ok & ~a_on;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(negedge clk_a or negedge rst_n)
        if (!rst_n) a_q <= '0; else a_q <= a_want;
      always_ff @(negedge clk_b or negedge rst_n)
        if (!rst_n) b_q <= '0; else b_q <= b_want;
    end else begin : g_many
      always_ff @(negedge clk_a or negedge rst_n)
        if (!rst_n) a_q <= '0; else a_q <= {a_q[SYNC_STAGES-2:0], a_want};
      always_ff @(negedge clk_b or negedge rst_n)
        if (!rst_n) b_q <= '0; else b_q <= {b_q[SYNC_STAGES-2:0], b_want};
    end
  endgenerate

  assign a_on  = a_q[SYNC_STAGES-1];
  assign b_on  = b_q[SYNC_STAGES-1];
  assign clk_o = (clk_a & a_on) | (clk_b & b_on);
endmodule

// File: rtl/mclk_aux_div.sv
`timescale 1ns/1ps
module mclk_aux_div
  import mclk_sel_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       clk_o
);
  localparam int TAP_W = (STAGES < 1) ? 1 : $clog2(STAGES + 1);
  localparam int NTAPS = 1 << TAP_W;

  logic [STAGES-1:0] cnt_q;
  logic [NTAPS-1:0]  taps;
  logic [TAP_W-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    if (g == 0) begin : g_pass
      assign taps[g] = clk;
    end else if (g <= STAGES) begin : g_stage
      assign taps[g] = cnt_q[g-1];
    end else begin : g_clamp
      assign taps[g] = cnt_q[STAGES-1];
    end
  end

  always_comb begin
    if (int'(aux_tap(code)) > STAGES) sel = TAP_W'(STAGES);
    else                               sel = TAP_W'(aux_tap(code));
  end

  assign clk_o = taps[sel];
endmodule

// File: rtl/mclk_rate_mon.sv
`timescale 1ns/1ps
module mclk_rate_mon
  import mclk_sel_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int WIN_W = 12,
  parameter int TOL   = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             mclk,
  input  logic [WIN_W-1:0] win_len,
  input  logic             mask,
  input  logic             clear,
  input  logic             hold,
  output logic             rate_err,
  output logic             win_end
);
  logic [2:0]       ms_q;
  logic             rise;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_tot, stored_q;
  logic             valid_q, dirty_q, err_q, dev;

  assign rise    = ms_q[1] & ~ms_q[2];
  assign cnt_tot = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(rise);
  assign win_end = ({1'b0, win_q} + (WIN_W+1)'(1)) >= {1'b0, win_len};
  assign dev     = rate_deviates(16'(cnt_tot), 16'(stored_q), 8'(TOL));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q     <= '0;
      win_q    <= '0;
      cnt_q    <= '0;
      stored_q <= '0;
      valid_q  <= 1'b0;
      dirty_q  <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      ms_q <= {ms_q[1:0], mclk};
      if (win_end) begin
        win_q   <= '0;
        cnt_q   <= '0;
        dirty_q <= hold | clear;
        if (clear) begin
          stored_q <= '0;
          valid_q  <= 1'b1;
          err_q    <= 1'b0;
        end else if (dirty_q | hold) begin
          err_q <= 1'b0;
        end else begin
          err_q    <= valid_q & dev & ~mask;
          stored_q <= cnt_tot;
          valid_q  <= 1'b1;
        end
      end else begin
        win_q <= win_q + 1'b1;
        cnt_q <= cnt_tot;
        if (hold | clear) dirty_q <= 1'b1;
        if (clear) begin
          stored_q <= '0;
          valid_q  <= 1'b1;
        end
      end
    end
  end

  assign rate_err = err_q;
endmodule

// File: rtl/mclk_source_sel.sv
`timescale 1ns/1ps
module mclk_source_sel #(
  parameter int CNT_W       = 10,
  parameter int WIN_W       = 12,
  parameter int RATE_TOL    = 2,
  parameter int OSC_STARTUP = 1024,
  parameter int AUX_STAGES  = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             pll_clk,
  input  logic             pll_lock,
  input  logic             osc_clk,
  input  logic             cfg_src_osc,
  input  logic             cfg_amp_always,
  input  logic             cfg_err_mask,
  input  logic             cfg_pll_div2,
  input  logic [1:0]       cfg_aux_div,
  input  logic [WIN_W-1:0] cfg_win_len,
  output logic             mclk_out,
  output logic             aux_clk_out,
  output logic             amp_en,
  output logic             rate_err
);
  // PLL-path pre-divider
  logic pll_half_q, pll_src;
  always_ff @(posedge pll_clk or negedge rst_n)
    if (!rst_n) pll_half_q <= 1'b0;
    else        pll_half_q <= ~pll_half_q;
  assign pll_src = cfg_pll_div2 ? pll_half_q : pll_clk;

  // clock-domain status brought into ref_clk
  logic osc_run, pll_on, osc_on;
  logic [1:0] lock_sy, run_sy, pon_sy, oon_sy;
  logic lock_s, osc_run_s, pll_on_s, osc_on_s;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_sy <= '0; run_sy <= '0; pon_sy <= '0; oon_sy <= '0;
    end else begin
      lock_sy <= {lock_sy[0], pll_lock};
      run_sy  <= {run_sy[0],  osc_run};
      pon_sy  <= {pon_sy[0],  pll_on};
      oon_sy  <= {oon_sy[0],  osc_on};
    end
  end
  assign lock_s    = lock_sy[1];
  assign osc_run_s = run_sy[1];
  assign pll_on_s  = pon_sy[1];
  assign osc_on_s  = oon_sy[1];

  // source control
  logic want_osc, sel_osc_nxt, sel_osc_q, amp_en_q, cold_q;
  logic rate_clear, handover_busy, mon_win_end;

  assign want_osc    = cfg_src_osc | ~lock_s;
  assign sel_osc_nxt = want_osc & osc_run_s;
  assign rate_clear  = cold_q & sel_osc_nxt & ~sel_osc_q;
  assign handover_busy = sel_osc_q ? (~osc_on_s | pll_on_s)
                                   : (~pll_on_s | osc_on_s);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_osc_q <= 1'b0;
      amp_en_q  <= 1'b0;
      cold_q    <= 1'b0;
    end else begin
      sel_osc_q <= sel_osc_nxt;
      amp_en_q  <= cfg_amp_always | want_osc | osc_on_s;
      if (!want_osc)                                  cold_q <= 1'b0;
      else if (!amp_en_q && !cfg_amp_always)          cold_q <= 1'b1;
      else if (rate_clear)                            cold_q <= 1'b0;
    end
  end
  assign amp_en = amp_en_q;

  mclk_osc_startup #(.STARTUP(OSC_STARTUP)) u_startup (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .amp_en  (amp_en_q),
    .osc_run (osc_run)
  );

  mclk_glitchfree_mux #(.SYNC_STAGES(2)) u_mux (
    .rst_n  (rst_n),
    .clk_a  (pll_src),
    .clk_b  (osc_clk),
    .pick_b (sel_osc_q),
    .b_ok   (osc_run),
    .clk_o  (mclk_out),
    .a_on   (pll_on),
    .b_on   (osc_on)
  );

  mclk_aux_div #(.STAGES(AUX_STAGES)) u_aux (
    .clk   (mclk_out),
    .rst_n (rst_n),
    .code  (cfg_aux_div),
    .clk_o (aux_clk_out)
  );

  mclk_rate_mon #(.CNT_W(CNT_W), .WIN_W(WIN_W), .TOL(RATE_TOL)) u_mon (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .mclk     (mclk_out),
    .win_len  (cfg_win_len),
    .mask     (cfg_err_mask),
    .clear    (rate_clear),
    .hold     (handover_busy),
    .rate_err (rate_err),
    .win_end  (mon_win_end)
  );
endmodule

// File: rtl/mclk_source_sel_chk.sv
`timescale 1ns/1ps
module mclk_source_sel_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic cfg_src_osc,
  input logic cfg_amp_always,
  input logic cfg_err_mask,
  input logic amp_en,
  input logic rate_err,
  input logic pll_on,
  input logic osc_on,
  input logic osc_run_s,
  input logic sel_osc_q,
  input logic lock_s,
  input logic mon_win_end
);
  AST_SINGLE_SOURCE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(pll_on && osc_on));  // R5

  AST_UNLOCK_WAKES_AMP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !lock_s |=> amp_en);  // R2

  AST_OSC_AFTER_READY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sel_osc_q) |-> osc_run_s);  // R3

  AST_PLL_WHEN_ASKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(sel_osc_q) |-> $past(lock_s && !cfg_src_osc));  // R4

  AST_AMP_CONTINUOUS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_amp_always |=> amp_en);  // R6

  AST_ERR_ON_WINDOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (rate_err != $past(rate_err)) |-> $past(mon_win_end));  // R7

  AST_MASKED_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(rate_err) |-> !$past(cfg_err_mask));  // R8
endmodule

bind mclk_source_sel mclk_source_sel_chk u_chk (
  .ref_clk        (ref_clk),
  .rst_n          (rst_n),
  .cfg_src_osc    (cfg_src_osc),
  .cfg_amp_always (cfg_amp_always),
  .cfg_err_mask   (cfg_err_mask),
  .amp_en         (amp_en),
  .rate_err       (rate_err),
  .pll_on         (pll_on),
  .osc_on         (osc_on),
  .osc_run_s      (osc_run_s),
  .sel_osc_q      (sel_osc_q),
  .lock_s         (lock_s),
  .mon_win_end    (mon_win_end)
);

// File: tb/mclk_source_sel_bench.sv
`timescale 1ns/1ps
module mclk_source_sel_bench;
  localparam int  WIN_W   = 12;
  localparam int  STARTUP = 16;
  localparam int  WIN_REF = 256;
  localparam real WIN_NS  = 256.0 * 5.0;

  logic ref_clk = 0, rst_n = 0, pll_clk = 0, osc_clk = 0, pll_lock = 1;
  logic cfg_src_osc = 0, cfg_amp_always = 0, cfg_err_mask = 0, cfg_pll_div2 = 0;
  logic [1:0] cfg_aux_div = 0;
  logic [WIN_W-1:0] cfg_win_len = WIN_W'(WIN_REF);
  logic mclk_out, aux_clk_out, amp_en, rate_err;

  real pll_half = 20.0;
  int  n_checks = 0, n_fail = 0;

  always #2.5 ref_clk = ~ref_clk;
  initial forever begin #(pll_half); pll_clk = ~pll_clk; end
  initial begin #33; forever begin osc_clk = ~osc_clk; #20; end end

  mclk_source_sel #(.WIN_W(WIN_W), .OSC_STARTUP(STARTUP)) u_mclk_source_sel (
    .ref_clk(ref_clk), .rst_n(rst_n), .pll_clk(pll_clk), .pll_lock(pll_lock),
    .osc_clk(osc_clk), .cfg_src_osc(cfg_src_osc), .cfg_amp_always(cfg_amp_always),
    .cfg_err_mask(cfg_err_mask), .cfg_pll_div2(cfg_pll_div2), .cfg_aux_div(cfg_aux_div),
    .cfg_win_len(cfg_win_len), .mclk_out(mclk_out), .aux_clk_out(aux_clk_out),
    .amp_en(amp_en), .rate_err(rate_err));

  // observers: source identity, periods, pulse widths, error pulses
  real mclk_last = 0.0, mclk_per = 0.0, aux_last = 0.0, aux_per = 0.0;
  real edge_last = 0.0, min_pulse = 1.0e9, err_rise_t = 0.0, err_width = 0.0;
  bit  src_osc = 0, track = 0, armed = 0;
  int  err_rises = 0;

  always @(posedge mclk_out) begin
    mclk_per  = $realtime - mclk_last;
    mclk_last = $realtime;
    src_osc   = osc_clk;
  end
  always @(posedge aux_clk_out) begin
    aux_per  = $realtime - aux_last;
    aux_last = $realtime;
  end
  always @(mclk_out) if (track) begin
    if (armed && ($realtime - edge_last) < min_pulse) min_pulse = $realtime - edge_last;
    edge_last = $realtime;
    armed = 1;
  end
  always @(posedge rate_err) begin err_rises++; err_rise_t = $realtime; end
  always @(negedge rate_err) err_width = $realtime - err_rise_t;

  function automatic int ns(input real t);
    return $rtoi(t + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_windows(input int n);
    #(WIN_NS * n);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #99;
    check(mclk_out == 0 && rate_err == 0 && amp_en == 0, "reset outputs idle",
          {29'd0, mclk_out, rate_err, amp_en}, 0);
    #1 rst_n = 1;
    #200 track = 1;
    wait_windows(4);

    // R1 / R10 code 0: steady PLL output, undivided
    check(src_osc == 0, "R1 output from pll", src_osc, 0);
    check(ns(mclk_per) == 40, "R10 pll divide-by-1 period", ns(mclk_per), 40);
    check(amp_en == 0, "R1 amplifier idle while on pll", amp_en, 0);

    // R11: auxiliary divide sweep
    for (int c = 0; c < 4; c++) begin
      int exp_per;
      cfg_aux_div = 2'(c);
      exp_per = 40 * ((c == 0) ? 1 : (c == 1) ? 2 : 4);
      #700;
      check(ns(aux_per) == exp_per, $sformatf("R11 aux code %0d period", c), ns(aux_per), exp_per);
    end
    cfg_aux_div = 0;

    // R3 / R7: cold switch to the oscillator
    err_rises = 0;
    cfg_src_osc = 1;
    #30 check(amp_en == 1, "R3 amplifier started on request", amp_en, 1);
    #570 check(src_osc == 0, "R3 no oscillator before startup", src_osc, 0);
    #900 check(src_osc == 1, "R3 oscillator after startup", src_osc, 1);
    check(ns(mclk_per) == 40, "R3 oscillator period", ns(mclk_per), 40);
    wait_windows(6);
    check(err_rises == 1, "R7 one error pulse after cold switch", err_rises, 1);
    check(ns(err_width) == ns(WIN_NS), "R7 error pulse lasts one window", ns(err_width), ns(WIN_NS));

    // R4 / R10: back to a halved PLL clock
    cfg_pll_div2 = 1;
    #100 cfg_src_osc = 0;
    #500 check(src_osc == 0, "R4 quick return to pll", src_osc, 0);
    #400 check(ns(mclk_per) == 80, "R10 pll divide-by-2 period", ns(mclk_per), 80);

    // R6: continuous amplifier, no startup wait
    cfg_amp_always = 1;
    #1500;
    check(amp_en == 1, "R6 amplifier held on", amp_en, 1);
    cfg_src_osc = 1;
    #400 check(src_osc == 1, "R6 oscillator without startup wait", src_osc, 1);
    cfg_pll_div2 = 0;
    #100 cfg_src_osc = 0;
    wait_windows(8);

    // R9: equal-rate switches with amplifier always on
    err_rises = 0;
    cfg_src_osc = 1;
    #3000 cfg_src_osc = 0;
    wait_windows(6);
    check(err_rises == 0, "R9 no error with continuous amplifier", err_rises, 0);
    check(amp_en == 1, "R6 amplifier still on after return", amp_en, 1);

    // R8: masked cold switch
    cfg_amp_always = 0;
    cfg_err_mask = 1;
    #1000;
    err_rises = 0;
    cfg_src_osc = 1;
    #3000 check(src_osc == 1, "R8 cold switch reached oscillator", src_osc, 1);
    cfg_src_osc = 0;
    wait_windows(6);
    check(err_rises == 0, "R8 masked error stays low", err_rises, 0);
    cfg_err_mask = 0;

    // R2: fallback on loss of lock, then relock
    #1000;
    pll_lock = 0;
    #50 check(amp_en == 1, "R2 amplifier wakes on unlock", amp_en, 1);
    #1500 check(src_osc == 1, "R2 automatic move to oscillator", src_osc, 1);
    pll_lock = 1;
    #500 check(src_osc == 0, "R4 return to pll on relock", src_osc, 0);
    wait_windows(8);
    check(rate_err == 0, "R12 steady rate keeps flag low", rate_err, 0);

    // R12: PLL rate step
    err_rises = 0;
    pll_half = 30.0;
    wait_windows(6);
    check(err_rises == 1, "R12 one pulse on rate step", err_rises, 1);
    check(rate_err == 0, "R12 flag low once rate steady", rate_err, 0);
    pll_half = 20.0;
    wait_windows(6);

    check(ns(min_pulse) >= 20, "R5 no runt pulse on mclk_out", ns(min_pulse), 20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule